// File: doc/BRIEF.md
# Palette Address Masking and Paging Unit

This block builds the colour-palette RAM address for each pixel in pseudo-colour and overlay modes. The pixel arrives as an 8-bit value together with a two-bit code that says how many bit-planes it really carries: eight, four, two or one. The active low-order pixel bits are first ANDed with a programmable read mask. The high address positions that a narrow pixel leaves empty are then filled from a programmable page register. Because masking happens before paging, the page bits are never affected by the mask.

The read mask and the page register sit behind a small synchronous register port. The port has a select line, a write strobe, write data and a registered read-back. The palette address leaves the block through one register stage, so the address for a pixel appears one clock after that pixel is presented. A register write that lands in the same cycle as a pixel affects only the pixels presented after it.

Top module: `pal_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the palette address output is 0x00, the read mask holds 0xFF and the page register holds 0x00.
- R2: With `reg_we` high at a clock edge, `reg_sel` = 0 writes `reg_wdata` into the read mask and `reg_sel` = 1 writes it into the page register. `reg_rdata` shows, one clock after an edge, the register chosen by `reg_sel` at that edge, with the value it held before that edge.
- R3: Plane code 0 (eight planes): every address bit equals the pixel bit ANDed with the matching mask bit.
- R4: Plane code 1 (four planes): address bits 7..4 equal page bits 7..4, and address bits 3..0 equal pixel bits 3..0 ANDed with mask bits 3..0.
- R5: Plane code 2 (two planes): address bits 7..2 equal page bits 7..2, and address bits 1..0 equal the masked pixel bits 1..0.
- R6: Plane code 3 (one plane): address bits 7..1 equal page bits 7..1, and address bit 0 equals pixel bit 0 ANDed with mask bit 0.
- R7: Page bits reach the address unchanged even when the matching read-mask bits are zero.
- R8: Pixel bits and read-mask bits above the active plane count have no effect on the address.
- R9: The address for a pixel and plane code appears exactly one clock after they are presented, and it does not change before that edge.
- R10: A register write in the same cycle as a pixel does not affect that pixel's address. It does affect the pixel presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixel | input | 8 | Pixel-port data |
| plane_code | input | 2 | Active bit-planes: 0 = 8, 1 = 4, 2 = 2, 3 = 1 |
| reg_sel | input | 1 | Register select: 0 = read mask, 1 = page |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read-back of the selected register |
| pal_addr | output | 8 | Registered palette RAM address |

## Verification
Two functions can meet in one cycle: a register write and the address lookup for a pixel. The bench provokes this by raising the write strobe on the same clock as a new pixel. It then checks that this pixel's address is built from the mask or page value held before the write, and that the pixel held into the next cycle sees the new value. A second pair is the mask against the page register in narrow modes. Here an all-zero mask is set together with a nonzero page, and the bench checks that only the low pixel bits are cleared.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    PLANES_FULL = 2'd0,
    PLANES_HALF = 2'd1,
    PLANES_TWO  = 2'd2,
    PLANES_ONE  = 2'd3
  } plane_mode_e;

  localparam logic SEL_MASK = 1'b0;
  localparam logic SEL_PAGE = 1'b1;

  // number of low address bits that come from the pixel port
  function automatic int unsigned pixel_planes(plane_mode_e m, int unsigned w);
    case (m)
      PLANES_FULL: return w;
      PLANES_HALF: return w / 2;
      PLANES_TWO:  return 2;
      default:     return 1;
    endcase
  endfunction

endpackage

// File: rtl/pal_regs.sv
module pal_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] page_o,
  output logic [W-1:0] rdata_o
);
  import pal_pkg::*;

  localparam logic [W-1:0] MASK_RST = {W{1'b1}};
  localparam logic [W-1:0] PAGE_RST = '0;

  logic [W-1:0] mask_q, page_q, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= MASK_RST;
      page_q  <= PAGE_RST;
      rdata_q <= '0;
    end else begin
      rdata_q <= (sel_i == SEL_PAGE) ? page_q : mask_q;
      if (we_i) begin
        if (sel_i == SEL_PAGE) page_q <= wdata_i;
        else                   mask_q <= wdata_i;
      end
    end
  end

  assign mask_o  = mask_q;
  assign page_o  = page_q;
  assign rdata_o = rdata_q;

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel_i == SEL_MASK) |=> mask_q == $past(wdata_i));
  // R2
  page_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && sel_i == SEL_PAGE) |=> page_q == $past(wdata_i));
  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> ($stable(mask_q) && $stable(page_q)));

endmodule

// File: rtl/pal_addr_merge.sv
module pal_addr_merge #(
  parameter int unsigned W = 8
) (
  input  pal_pkg::plane_mode_e mode_i,
  input  logic [W-1:0]         pixel_i,
  input  logic [W-1:0]         mask_i,
  input  logic [W-1:0]         page_i,
  output logic [W-1:0]         addr_o
);
  import pal_pkg::*;

  int unsigned planes;

  always_comb planes = pixel_planes(mode_i, W);

  // mask first, then page bits replace the unused upper positions
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign addr_o[i] = (planes > i) ? (pixel_i[i] & mask_i[i]) : page_i[i];
  end

endmodule

// File: rtl/pal_addr_gen.sv
module pal_addr_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pixel,
  input  logic [1:0]   plane_code,
  input  logic         reg_sel,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] pal_addr
);
  import pal_pkg::*;

  localparam int unsigned HALF = W / 2;

  plane_mode_e  mode;
  logic [W-1:0] mask_q, page_q, addr_d, addr_q;

  assign mode = plane_mode_e'(plane_code);

  pal_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (reg_sel),
    .we_i    (reg_we),
    .wdata_i (reg_wdata),
    .mask_o  (mask_q),
    .page_o  (page_q),
    .rdata_o (reg_rdata)
  );

  pal_addr_merge #(.W(W)) u_merge (
    .mode_i  (mode),
    .pixel_i (pixel),
    .mask_i  (mask_q),
    .page_i  (page_q),
    .addr_o  (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end

  assign pal_addr = addr_q;

  // R3
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PLANES_FULL) |=> addr_q == $past(pixel & mask_q));
  // R4
  half_page_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PLANES_HALF) |=> addr_q[W-1:HALF] == $past(page_q[W-1:HALF]));
  // R5
  two_page_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PLANES_TWO) |=> addr_q[W-1:2] == $past(page_q[W-1:2]));
  // R6
  one_plane_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == PLANES_ONE) |=> (addr_q[W-1:1] == $past(page_q[W-1:1]) &&
                              addr_q[0] == $past(pixel[0] & mask_q[0])));
  // R1
  reset_addr_chk: assert property (@(posedge clk)
    rst |=> addr_q == '0);

endmodule

// File: tb/test_pal_addr_gen.sv
module test_pal_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pixel = '0;
  logic [1:0] plane_code = '0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, pal_addr;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_addr_gen #(.W(8)) i_pal_addr_gen (
    .clk(clk), .rst(rst), .pixel(pixel), .plane_code(plane_code),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pal_addr(pal_addr)
  );

  function automatic logic [7:0] model(logic [7:0] p, logic [7:0] m,
                                       logic [7:0] pg, logic [1:0] code);
    logic [7:0] keep;
    case (code)
      2'd0: keep = 8'hFF;
      2'd1: keep = 8'h0F;
      2'd2: keep = 8'h03;
      default: keep = 8'h01;
    endcase
    return ((p & m) & keep) | (pg & ~keep);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(string req, logic sel, logic [7:0] exp);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic look(string req, logic [7:0] p, logic [1:0] code, logic [7:0] exp);
    @(negedge clk);
    pixel = p; plane_code = code;
    @(negedge clk);
    check(req, pal_addr, exp);
  endtask

  task automatic t_reset;
    check("R1 addr", pal_addr, 8'h00);
    read_reg("R1 mask", 1'b0, 8'hFF);
    read_reg("R1 page", 1'b1, 8'h00);
  endtask

  task automatic t_regs;
    write_reg(1'b0, 8'hA5);
    write_reg(1'b1, 8'h3C);
    read_reg("R2 mask", 1'b0, 8'hA5);
    read_reg("R2 page", 1'b1, 8'h3C);
  endtask

  task automatic t_full;
    write_reg(1'b0, 8'hA5);
    look("R3 a", 8'hFF, 2'd0, 8'hA5);
    look("R3 b", 8'h3C, 2'd0, model(8'h3C, 8'hA5, 8'h3C, 2'd0));
    write_reg(1'b0, 8'hFF);
    look("R3 c", 8'h96, 2'd0, 8'h96);
  endtask

  task automatic t_narrow;
    write_reg(1'b1, 8'hB7);
    write_reg(1'b0, 8'hFF);
    look("R4", 8'h5A, 2'd1, 8'hBA);
    look("R5", 8'h5A, 2'd2, model(8'h5A, 8'hFF, 8'hB7, 2'd2));
    look("R6 a", 8'h5A, 2'd3, 8'hB6);
    look("R6 b", 8'h01, 2'd3, 8'hB7);
  endtask

  task automatic t_page_unmasked;
    write_reg(1'b1, 8'hE8);
    write_reg(1'b0, 8'h00);
    look("R7 half", 8'hFF, 2'd1, 8'hE0);
    look("R7 one", 8'hFF, 2'd3, 8'hE8);
  endtask

  task automatic t_upper_ignored;
    write_reg(1'b1, 8'h40);
    write_reg(1'b0, 8'h0F);
    look("R8 pix", 8'hF5, 2'd1, 8'h45);
    look("R8 pix2", 8'h05, 2'd1, 8'h45);
    write_reg(1'b0, 8'hFF);
    look("R8 mask", 8'h05, 2'd1, 8'h45);
  endtask

  task automatic t_latency;
    write_reg(1'b0, 8'hFF);
    look("R9 setup", 8'h11, 2'd0, 8'h11);
    @(negedge clk);
    pixel = 8'h22;
    #1 check("R9 hold", pal_addr, 8'h11);
    @(negedge clk);
    check("R9 new", pal_addr, 8'h22);
  endtask

  task automatic t_same_cycle;
    write_reg(1'b0, 8'hFF);
    look("R10 setup", 8'hC3, 2'd0, 8'hC3);
    @(negedge clk);
    pixel = 8'hFF; reg_sel = 1'b0; reg_we = 1'b1; reg_wdata = 8'h0F;
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 old", pal_addr, 8'hFF);
    @(negedge clk);
    check("R10 new", pal_addr, 8'h0F);
    write_reg(1'b1, 8'h00);
    @(negedge clk);
    plane_code = 2'd1; pixel = 8'h0F; reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 8'h90;
    @(negedge clk);
    reg_we = 1'b0;
    check("R10 page old", pal_addr, 8'h0F);
    @(negedge clk);
    check("R10 page new", pal_addr, 8'h9F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", pal_addr, 8'h00);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_full();
    t_narrow();
    t_page_unmasked();
    t_upper_ignored();
    t_latency();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule